// File: doc/BRIEF.md
# Unimplemented-Function Trap and Resume Controller

This block sits between instruction decode and the program counter. Each decoded instruction presents its function number. The block decides whether that function runs in hardware on this machine model, or whether it must be handed to the supervisor software. A per-model bit vector, with one bit per function number, marks which functions the hardware carries out. A fixed band of peripheral transfer functions always goes to the supervisor, whatever the vector says.

When a user-mode instruction has to be handed over, the block suspends the program. It issues one store write holding a save word. The save word packs the status flags and the address of the current instruction. It is written at offset 8 above the program's base (datum) register, so each program keeps its own copy inside its own store area. In the same response the block sets supervisor mode and sends the program counter to a fixed supervisor entry address.

A later resume request carries the saved word back. The block then restores the flags, points the program counter at the instruction after the suspended one and leaves supervisor mode, all in a single response. If a handover is needed while supervisor mode is already set, the block reports it as an error and leaves the save word untouched. Every response appears on the outputs one clock after the request.

Top module: `xc_trap_ctrl`

## Requirements
- R1: While rst_n is low and on the first cycle after it rises, exec_mode, hw_go, st_req, pc_redir, flags_load and trap_err are all 0.
- R2: When dec_valid is 1 and dec_func selects a set bit of hw_func_set and lies outside the range IO_FIRST..IO_LAST, hw_go pulses for exactly the next cycle with st_req, pc_redir and trap_err at 0. This holds in either mode, and exec_mode is unchanged.
- R3: When dec_valid is 1 in user mode and dec_func selects a clear bit of hw_func_set, st_req pulses the next cycle with st_addr equal to (datum + 8) modulo 2^AW.
- R4: A dec_func inside IO_FIRST..IO_LAST is handed to the supervisor even when its hw_func_set bit is 1, and never produces hw_go.
- R5: The save word st_data holds dec_pc in bits [PC_W-1:0] and cur_flags in bits [WORD_W-1:WORD_W-FLAG_W], with every bit between them 0.
- R6: In the cycle st_req pulses, pc_redir is 1, pc_target equals EXEC_ENTRY and exec_mode is 1 from then on.
- R7: A handover needed while exec_mode is 1 pulses trap_err for one cycle. It raises neither st_req nor pc_redir, and exec_mode stays 1.
- R8: When ret_valid is 1 while exec_mode is 1, the next cycle shows pc_redir=1, pc_target equal to (ret_word[PC_W-1:0] + 1) modulo 2^PC_W, flags_load=1, flags_value equal to ret_word[WORD_W-1:WORD_W-FLAG_W] and exec_mode=0.
- R9: ret_valid while exec_mode is 0 is ignored: pc_redir and flags_load stay 0 and exec_mode stays 0.
- R10: When ret_valid and dec_valid are both 1 while exec_mode is 1, the resume is carried out and the decode is dropped: no st_req, no trap_err and no hw_go.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | A decoded instruction is presented |
| dec_func | input | FUNC_W | Function number of the decoded instruction |
| dec_pc | input | PC_W | Address of the decoded instruction |
| cur_flags | input | FLAG_W | Current status flags (overflow, carry, ...) |
| hw_func_set | input | 2**FUNC_W | Per-model set: bit f = 1 means function f is done in hardware |
| datum | input | AW | Base address of the running program's store area |
| ret_valid | input | 1 | Resume request from the supervisor |
| ret_word | input | WORD_W | Save word to resume from |
| exec_mode | output | 1 | Supervisor mode flag |
| hw_go | output | 1 | Function is executed by hardware |
| st_req | output | 1 | Store write request for the save word |
| st_addr | output | AW | Store write address |
| st_data | output | WORD_W | Save word |
| pc_redir | output | 1 | Program counter redirect |
| pc_target | output | PC_W | Redirect address |
| flags_load | output | 1 | Restore flags from flags_value |
| flags_value | output | FLAG_W | Flags to restore |
| trap_err | output | 1 | Handover requested while already in supervisor mode |

## Verification
The bench builds the block with FUNC_W=4 and the peripheral band set to 12..13. With sixteen function numbers, every function can be tried under four hardware sets: all set, all clear, and two alternating patterns. That covers each combination of set bit, clear bit and peripheral band. For every handover the bench also tries a nested handover, a combined resume and decode, or a plain resume. The datum values wrap the save address past the top of the address space, and one saved address of all ones checks that the resume address wraps to zero.

// File: rtl/xc_pkg.sv
package xc_pkg;

    // Outcome chosen for one cycle of requests
    typedef enum logic [2:0] {
        CAUSE_NONE,
        CAUSE_HW,
        CAUSE_TRAP,
        CAUSE_NEST,
        CAUSE_RESUME
    } xc_cause_e;

endpackage

// File: rtl/xc_func_class.sv
module xc_func_class #(
    parameter int FUNC_W   = 7,
    parameter int IO_FIRST = 112,
    parameter int IO_LAST  = 119
) (
    input  logic [FUNC_W-1:0]      func,
    input  logic [(1<<FUNC_W)-1:0] hw_set,
    output logic                   is_io,
    output logic                   in_hw
);
    localparam int NFUNC = 1 << FUNC_W;

    logic [NFUNC-1:0] io_band;

    // Peripheral band is fixed at elaboration time
    for (genvar f = 0; f < NFUNC; f++) begin : g_band
        assign io_band[f] = (f >= IO_FIRST) && (f <= IO_LAST);
    end

    always_comb begin
        is_io = io_band[func];
        in_hw = hw_set[func] & ~io_band[func];
    end

endmodule

// File: rtl/xc_word_pack.sv
module xc_word_pack #(
    parameter int PC_W   = 15,
    parameter int FLAG_W = 3,
    parameter int WORD_W = 24
) (
    input  logic [PC_W-1:0]   pack_pc,
    input  logic [FLAG_W-1:0] pack_flags,
    output logic [WORD_W-1:0] pack_word,
    input  logic [WORD_W-1:0] unpack_word,
    output logic [PC_W-1:0]   unpack_pc,
    output logic [FLAG_W-1:0] unpack_flags
);
    localparam int GAP_W = WORD_W - PC_W - FLAG_W;

    always_comb begin
        pack_word    = {pack_flags, {GAP_W{1'b0}}, pack_pc};
        unpack_pc    = unpack_word[PC_W-1:0];
        unpack_flags = unpack_word[WORD_W-1 -: FLAG_W];
    end

endmodule

// File: rtl/xc_trap_ctrl.sv
module xc_trap_ctrl #(
    parameter int FUNC_W     = 7,
    parameter int PC_W       = 15,
    parameter int FLAG_W     = 3,
    parameter int WORD_W     = 24,
    parameter int AW         = 22,
    parameter int SAVE_OFS   = 8,
    parameter int IO_FIRST   = 112,
    parameter int IO_LAST    = 119,
    parameter int EXEC_ENTRY = 20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   dec_valid,
    input  logic [FUNC_W-1:0]      dec_func,
    input  logic [PC_W-1:0]        dec_pc,
    input  logic [FLAG_W-1:0]      cur_flags,
    input  logic [(1<<FUNC_W)-1:0] hw_func_set,
    input  logic [AW-1:0]          datum,
    input  logic                   ret_valid,
    input  logic [WORD_W-1:0]      ret_word,
    output logic                   exec_mode,
    output logic                   hw_go,
    output logic                   st_req,
    output logic [AW-1:0]          st_addr,
    output logic [WORD_W-1:0]      st_data,
    output logic                   pc_redir,
    output logic [PC_W-1:0]        pc_target,
    output logic                   flags_load,
    output logic [FLAG_W-1:0]      flags_value,
    output logic                   trap_err
);
    import xc_pkg::*;

    localparam logic [AW-1:0]   OFS_V   = AW'(SAVE_OFS);
    localparam logic [PC_W-1:0] ENTRY_V = PC_W'(EXEC_ENTRY);
    localparam logic [PC_W-1:0] ONE_PC  = PC_W'(1);

    typedef struct packed {
        logic              exec;
        logic              hw_go;
        logic              st_req;
        logic [AW-1:0]     st_addr;
        logic [WORD_W-1:0] st_data;
        logic              redir;
        logic [PC_W-1:0]   tgt;
        logic              fl_ld;
        logic [FLAG_W-1:0] fl_val;
        logic              err;
    } ctl_t;

    ctl_t      ctl_d, ctl_q;
    xc_cause_e cause;

    logic              f_is_io, f_in_hw;
    logic [WORD_W-1:0] save_word;
    logic [PC_W-1:0]   ret_pc;
    logic [FLAG_W-1:0] ret_flags;

    xc_func_class #(
        .FUNC_W  (FUNC_W),
        .IO_FIRST(IO_FIRST),
        .IO_LAST (IO_LAST)
    ) class_i (
        .func  (dec_func),
        .hw_set(hw_func_set),
        .is_io (f_is_io),
        .in_hw (f_in_hw)
    );

    xc_word_pack #(
        .PC_W  (PC_W),
        .FLAG_W(FLAG_W),
        .WORD_W(WORD_W)
    ) pack_i (
        .pack_pc     (dec_pc),
        .pack_flags  (cur_flags),
        .pack_word   (save_word),
        .unpack_word (ret_word),
        .unpack_pc   (ret_pc),
        .unpack_flags(ret_flags)
    );

    // Resume outranks decode; resume outside supervisor mode is ignored
    always_comb begin
        if (ret_valid && ctl_q.exec)  cause = CAUSE_RESUME;
        else if (!dec_valid)          cause = CAUSE_NONE;
        else if (f_in_hw)             cause = CAUSE_HW;
        else if (ctl_q.exec)          cause = CAUSE_NEST;
        else                          cause = CAUSE_TRAP;
    end

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.hw_go  = 1'b0;
        ctl_d.st_req = 1'b0;
        ctl_d.redir  = 1'b0;
        ctl_d.fl_ld  = 1'b0;
        ctl_d.err    = 1'b0;
        unique case (cause)
            CAUSE_HW: begin
                ctl_d.hw_go = 1'b1;
            end
            CAUSE_TRAP: begin
                ctl_d.st_req  = 1'b1;
                ctl_d.st_addr = datum + OFS_V;
                ctl_d.st_data = save_word;
                ctl_d.redir   = 1'b1;
                ctl_d.tgt     = ENTRY_V;
                ctl_d.exec    = 1'b1;
            end
            CAUSE_NEST: begin
                ctl_d.err = 1'b1;
            end
            CAUSE_RESUME: begin
                ctl_d.redir  = 1'b1;
                ctl_d.tgt    = ret_pc + ONE_PC;
                ctl_d.fl_ld  = 1'b1;
                ctl_d.fl_val = ret_flags;
                ctl_d.exec   = 1'b0;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign exec_mode   = ctl_q.exec;
    assign hw_go       = ctl_q.hw_go;
    assign st_req      = ctl_q.st_req;
    assign st_addr     = ctl_q.st_addr;
    assign st_data     = ctl_q.st_data;
    assign pc_redir    = ctl_q.redir;
    assign pc_target   = ctl_q.tgt;
    assign flags_load  = ctl_q.fl_ld;
    assign flags_value = ctl_q.fl_val;
    assign trap_err    = ctl_q.err;

    // R2
    hw_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_go |-> (!st_req && !pc_redir && !trap_err && $stable(exec_mode)));

    // R3
    save_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_req |-> (st_addr == $past(datum) + OFS_V));

    // R6
    entry_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_req |-> (pc_redir && pc_target == ENTRY_V && exec_mode && !$past(exec_mode)));

    // R7
    nest_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_err |-> (!st_req && !pc_redir && exec_mode && $past(exec_mode)));

    // R8
    resume_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(exec_mode) |-> (pc_redir && flags_load));

    // R9
    resume_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_load |-> $past(exec_mode));

endmodule

// File: tb/xc_trap_ctrl_tb.sv
module xc_trap_ctrl_tb_top;

    localparam int FUNC_W = 4;
    localparam int NF     = 1 << FUNC_W;
    localparam int PC_W   = 15;
    localparam int FLAG_W = 3;
    localparam int WORD_W = 24;
    localparam int AW     = 22;
    localparam int IO_LO  = 12;
    localparam int IO_HI  = 13;
    localparam int ENTRY  = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              dec_valid = 1'b0;
    logic [FUNC_W-1:0] dec_func = '0;
    logic [PC_W-1:0]   dec_pc = '0;
    logic [FLAG_W-1:0] cur_flags = '0;
    logic [NF-1:0]     hw_func_set = '0;
    logic [AW-1:0]     datum = '0;
    logic              ret_valid = 1'b0;
    logic [WORD_W-1:0] ret_word = '0;
    logic              exec_mode, hw_go, st_req, pc_redir, flags_load, trap_err;
    logic [AW-1:0]     st_addr;
    logic [WORD_W-1:0] st_data;
    logic [PC_W-1:0]   pc_target;
    logic [FLAG_W-1:0] flags_value;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    xc_trap_ctrl #(
        .FUNC_W(FUNC_W), .PC_W(PC_W), .FLAG_W(FLAG_W), .WORD_W(WORD_W),
        .AW(AW), .SAVE_OFS(8), .IO_FIRST(IO_LO), .IO_LAST(IO_HI),
        .EXEC_ENTRY(ENTRY)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_func(dec_func),
        .dec_pc(dec_pc), .cur_flags(cur_flags), .hw_func_set(hw_func_set),
        .datum(datum), .ret_valid(ret_valid), .ret_word(ret_word),
        .exec_mode(exec_mode), .hw_go(hw_go), .st_req(st_req), .st_addr(st_addr),
        .st_data(st_data), .pc_redir(pc_redir), .pc_target(pc_target),
        .flags_load(flags_load), .flags_value(flags_value), .trap_err(trap_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, sample at the next falling edge
    task automatic step(input bit dv, input int f, input logic [PC_W-1:0] pc,
                        input logic [FLAG_W-1:0] fl, input bit rv, input logic [WORD_W-1:0] rw);
        dec_valid = dv;
        dec_func  = FUNC_W'(f);
        dec_pc    = pc;
        cur_flags = fl;
        ret_valid = rv;
        ret_word  = rw;
        @(negedge clk);
        dec_valid = 1'b0;
        ret_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [NF-1:0] masks [4];
        logic [AW-1:0] datums [4];
        masks[0] = 16'hFFFF; masks[1] = 16'h0000; masks[2] = 16'hA5A5; masks[3] = 16'h5A5A;
        datums[0] = 22'h3FFFFC; datums[1] = 22'h000100; datums[2] = 22'h012345; datums[3] = 22'h3FFFF8;

        @(negedge clk);
        // R1 reset state while held
        chk("R1 exec", exec_mode, 0);
        chk("R1 pulses", {hw_go, st_req, pc_redir, flags_load, trap_err}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 exec after release", exec_mode, 0);
        chk("R1 pulses after release", {hw_go, st_req, pc_redir, flags_load, trap_err}, 0);

        for (int m = 0; m < 4; m++) begin
            hw_func_set = masks[m];
            datum       = datums[m];
            // R9 resume in user mode is ignored
            step(1'b0, 0, '0, '0, 1'b1, 24'hE00123);
            chk("R9 no redirect", pc_redir, 0);
            chk("R9 no flag load", flags_load, 0);
            chk("R9 mode", exec_mode, 0);

            for (int f = 0; f < NF; f++) begin
                bit is_io, trap;
                logic [PC_W-1:0]   pc;
                logic [FLAG_W-1:0] fl;
                logic [WORD_W-1:0] saved, exp_word;
                logic [AW-1:0]     exp_addr;
                is_io = (f >= IO_LO) && (f <= IO_HI);
                trap  = is_io || !masks[m][f];
                pc    = (f == 15) ? 15'h7FFF : PC_W'(f * 1931 + m * 77);
                fl    = FLAG_W'(f + m);
                exp_word = {fl, 6'b0, pc};
                exp_addr = datums[m] + 22'd8;

                step(1'b1, f, pc, fl, 1'b0, '0);
                if (!trap) begin
                    chk("R2 hw_go", hw_go, 1);
                    chk("R2 no store/redirect/err", {st_req, pc_redir, trap_err}, 0);
                    chk("R2 mode", exec_mode, 0);
                    @(negedge clk);
                    chk("R2 single pulse", hw_go, 0);
                end else begin
                    chk(is_io ? "R4 io store req" : "R3 store req", st_req, 1);
                    chk("R4 no hw_go", hw_go, 0);
                    chk("R3 save addr", st_addr, exp_addr);
                    chk("R5 save word", st_data, exp_word);
                    chk("R6 redirect", pc_redir, 1);
                    chk("R6 entry", pc_target, ENTRY);
                    chk("R6 mode", exec_mode, 1);
                    saved = st_data;

                    // R7 nested handover
                    step(1'b1, f, pc + 1'b1, ~fl, 1'b0, '0);
                    chk("R7 err", trap_err, 1);
                    chk("R7 no store/redirect", {st_req, pc_redir}, 0);
                    chk("R7 mode", exec_mode, 1);
                    chk("R7 save word untouched", st_data, exp_word);

                    if (f % 2 == 0) begin
                        // R10 resume with a concurrent decode
                        step(1'b1, f, pc, fl, 1'b1, saved);
                        chk("R10 no store/err/hw", {st_req, trap_err, hw_go}, 0);
                    end else begin
                        step(1'b0, 0, '0, '0, 1'b1, saved);
                    end
                    chk("R8 redirect", pc_redir, 1);
                    chk("R8 target", pc_target, PC_W'(pc + 1));
                    chk("R8 flag load", flags_load, 1);
                    chk("R8 flags", flags_value, fl);
                    chk("R8 mode", exec_mode, 0);
                end
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule